// File: doc/BRIEF.md
# Two-Level Address Translation Cache with Victim Store

This block caches virtual-to-physical page translations in two levels. A direct-mapped primary array, indexed by the low bits of the virtual page number, answers most lookups in a single cycle. The primary array suffers conflict misses, so the translations it displaces are kept in a small fully associative victim store. Only when both levels miss does the block ask an external page walker for the translation.

A client presents a virtual page number while `req_ready` is high. The block answers with a one-cycle `resp_valid` pulse that carries the physical page number and a hit flag. On a double miss, `miss_req` rises with the pending page number on `miss_vpn` and stays high until the walker returns the translation on the refill inputs. A `flush` strobe invalidates both levels and drops any pending miss.

Top module: `vtlb`

## Requirements
- R1: After reset `resp_valid`, `resp_hit` and `miss_req` are 0, `req_ready` is 1, and every entry of both levels is invalid, so the first lookup of any page, page 0 included, ends in a refill request.
- R2: A lookup whose page sits valid in primary slot `vpn[IDX_W-1:0]` gives `resp_valid`=1, `resp_hit`=1 and the cached physical page one cycle after the request is accepted.
- R3: A lookup that misses the primary array searches the victim store in a second cycle. On a victim hit the response (hit=1, cached physical page) comes two cycles after acceptance and `miss_req` stays low.
- R4: When both levels miss, `miss_req` rises two cycles after acceptance with `miss_vpn` equal to the requested page and stays high until `refill_valid`. The cycle after the refill, `resp_valid`=1, `resp_hit`=0, `resp_ppn` equals `refill_ppn`, and `miss_req` is 0.
- R5: A refill writes the primary slot picked by the page's low `IDX_W` bits. If that slot held a valid entry, the displaced entry is written into the victim slot named by a round-robin pointer, which then advances by one and wraps after slot `VIC_N-1`. The pointer does not move when the displaced slot was invalid.
- R6: On a victim hit the two entries swap. The hit translation moves into its primary slot, and the displaced primary entry takes the freed victim slot. If the primary slot was invalid, the victim slot becomes invalid.
- R7: `flush` has priority over all else. The cycle after it, both levels are empty, the round-robin pointer is back at slot 0, `miss_req` is 0 and `req_ready` is 1, with no response for an abandoned lookup.
- R8: Invalid entries never match a lookup and are never moved into the victim store.
- R9: `req_ready` is low while a victim search or a refill is in progress. A request presented then is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ready | output | 1 | Block can accept a lookup |
| flush | input | 1 | Invalidate both levels and drop any pending miss |
| refill_valid | input | 1 | Walker returns a translation |
| refill_vpn | input | VPN_W | Virtual page of the returned translation |
| refill_ppn | input | PPN_W | Physical page of the returned translation |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response came from a cached entry |
| resp_ppn | output | PPN_W | Translated physical page number |
| miss_req | output | 1 | Translation request to the walker |
| miss_vpn | output | VPN_W | Page the walker must translate |

## Verification
The hardest state to reach is a full victim store whose round-robin pointer has wrapped, with swaps having already shuffled entries between the two levels. Only long chains of conflicting pages set that up. The random stimulus draws pages from a few tags over only four primary indices, so the same slots evict each other constantly and evicted pages come back as victim hits. Directed sequences add a two-page ping-pong on one slot, lookups of page 0 over reset-cleared entries, and a flush and a stray request while a miss is pending.

// File: rtl/vtlb.sv
module vtlb #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int IDX_W = 4,
  parameter int VIC_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             req_ready,
  input  logic             flush,
  input  logic             refill_valid,
  input  logic [VPN_W-1:0] refill_vpn,
  input  logic [PPN_W-1:0] refill_ppn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [PPN_W-1:0] resp_ppn,
  output logic             miss_req,
  output logic [VPN_W-1:0] miss_vpn
);
  localparam int PRI_N = 1 << IDX_W;
  localparam int PTR_W = (VIC_N > 1) ? $clog2(VIC_N) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_VSRCH, ST_WAIT} st_t;
  st_t state;

  logic [VPN_W-1:0] pri_vpn [PRI_N];
  logic [PPN_W-1:0] pri_ppn [PRI_N];
  logic [PRI_N-1:0] pri_v;
  logic [VPN_W-1:0] vic_vpn [VIC_N];
  logic [PPN_W-1:0] vic_ppn [VIC_N];
  logic [VIC_N-1:0] vic_v;
  logic [PTR_W-1:0] push_ptr;
  logic [VPN_W-1:0] cur_vpn;

  logic [IDX_W-1:0] req_idx, cur_idx, ref_idx;
  logic             pri_hit;
  logic [VIC_N-1:0] vic_match;
  logic [PTR_W-1:0] vic_sel;

  assign req_idx   = req_vpn[IDX_W-1:0];
  assign cur_idx   = cur_vpn[IDX_W-1:0];
  assign ref_idx   = refill_vpn[IDX_W-1:0];
  assign pri_hit   = pri_v[req_idx] && (pri_vpn[req_idx] == req_vpn);
  assign req_ready = (state == ST_IDLE);
  assign miss_vpn  = cur_vpn;

  for (genvar k = 0; k < VIC_N; k++) begin : g_cmp
    assign vic_match[k] = vic_v[k] && (vic_vpn[k] == cur_vpn);
  end

  always_comb begin
    vic_sel = '0;
    for (int k = VIC_N - 1; k >= 0; k--)
      if (vic_match[k]) vic_sel = PTR_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pri_v      <= '0;
      vic_v      <= '0;
      push_ptr   <= '0;
      cur_vpn    <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_ppn   <= '0;
      miss_req   <= 1'b0;
      for (int i = 0; i < PRI_N; i++) begin
        pri_vpn[i] <= '0;
        pri_ppn[i] <= '0;
      end
      for (int k = 0; k < VIC_N; k++) begin
        vic_vpn[k] <= '0;
        vic_ppn[k] <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      if (flush) begin
        pri_v    <= '0;
        vic_v    <= '0;
        push_ptr <= '0;
        miss_req <= 1'b0;
        state    <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (req_valid) begin
            cur_vpn <= req_vpn;
            if (pri_hit) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
              resp_ppn   <= pri_ppn[req_idx];
            end else begin
              state <= ST_VSRCH;
            end
          end
          ST_VSRCH: begin
            if (|vic_match) begin
              resp_valid       <= 1'b1;
              resp_hit         <= 1'b1;
              resp_ppn         <= vic_ppn[vic_sel];
              pri_vpn[cur_idx] <= cur_vpn;
              pri_ppn[cur_idx] <= vic_ppn[vic_sel];
              pri_v[cur_idx]   <= 1'b1;
              vic_vpn[vic_sel] <= pri_vpn[cur_idx];
              vic_ppn[vic_sel] <= pri_ppn[cur_idx];
              vic_v[vic_sel]   <= pri_v[cur_idx];
              state            <= ST_IDLE;
            end else begin
              miss_req <= 1'b1;
              state    <= ST_WAIT;
            end
          end
          ST_WAIT: if (refill_valid) begin
            miss_req         <= 1'b0;
            resp_valid       <= 1'b1;
            resp_ppn         <= refill_ppn;
            pri_vpn[ref_idx] <= refill_vpn;
            pri_ppn[ref_idx] <= refill_ppn;
            pri_v[ref_idx]   <= 1'b1;
            if (pri_v[ref_idx]) begin
              vic_vpn[push_ptr] <= pri_vpn[ref_idx];
              vic_ppn[push_ptr] <= pri_ppn[ref_idx];
              vic_v[push_ptr]   <= 1'b1;
              push_ptr <= (push_ptr == PTR_W'(VIC_N - 1)) ? '0 : push_ptr + 1'b1;
            end
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pri_v == '0 && vic_v == '0 && !miss_req && req_ready));

  assert_victim_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vic_match));

  assert_primary_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && pri_hit && !flush) |=> (resp_valid && resp_hit));

  assert_victim_no_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VSRCH && |vic_match && !flush) |=> (resp_valid && !miss_req));

  assert_miss_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && !refill_valid && !flush) |=> (miss_req && !resp_valid));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> !req_ready);
endmodule

// File: tb/vtlb_bench.sv
module vtlb_bench;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int IDX_W = 4;
  localparam int VIC_N = 8;
  localparam int PRI_N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic req_ready;
  logic flush = 1'b0;
  logic refill_valid = 1'b0;
  logic [VPN_W-1:0] refill_vpn = '0;
  logic [PPN_W-1:0] refill_ppn = '0;
  logic resp_valid, resp_hit, miss_req;
  logic [PPN_W-1:0] resp_ppn;
  logic [VPN_W-1:0] miss_vpn;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [VPN_W-1:0] m_pv [PRI_N];
  logic [PPN_W-1:0] m_pp [PRI_N];
  bit               m_pval [PRI_N];
  logic [VPN_W-1:0] m_vv [VIC_N];
  logic [PPN_W-1:0] m_vp [VIC_N];
  bit               m_vval [VIC_N];
  int               m_ptr;

  always #5 clk = ~clk;

  vtlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .VIC_N(VIC_N)) u_vtlb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_ready(req_ready), .flush(flush), .refill_valid(refill_valid),
    .refill_vpn(refill_vpn), .refill_ppn(refill_ppn), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_ppn(resp_ppn), .miss_req(miss_req), .miss_vpn(miss_vpn)
  );

  function automatic logic [PPN_W-1:0] walk(input logic [VPN_W-1:0] v);
    return {v[9:0], v[19:10]} ^ 20'h35C1B;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < PRI_N; i++) m_pval[i] = 0;
    for (int k = 0; k < VIC_N; k++) m_vval[k] = 0;
    m_ptr = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    model_clear();
    chk(req_ready && !miss_req && !resp_valid, "R7 flush idle", {req_ready, miss_req, resp_valid}, 3'b100);
  endtask

  // kind: 0 primary hit, 1 victim hit, 2 miss
  task automatic lookup(input logic [VPN_W-1:0] v, input bit stray, input bit abort);
    int idx, kind, slot;
    idx = int'(v[IDX_W-1:0]);
    kind = 2; slot = 0;
    if (m_pval[idx] && m_pv[idx] == v) kind = 0;
    else for (int k = 0; k < VIC_N; k++) if (m_vval[k] && m_vv[k] == v) begin kind = 1; slot = k; end

    @(negedge clk); req_valid = 1'b1; req_vpn = v;
    @(negedge clk); req_valid = 1'b0;
    if (kind == 0) begin
      chk(resp_valid && resp_hit, "R2 primary hit", {resp_valid, resp_hit}, 2'b11);
      chk(resp_ppn == walk(v), "R2 primary ppn", resp_ppn, walk(v));
      return;
    end
    chk(!resp_valid && !miss_req && !req_ready, "R3 R9 second cycle busy", {resp_valid, miss_req, req_ready}, 3'b000);
    @(negedge clk);
    if (kind == 1) begin
      chk(resp_valid && resp_hit && !miss_req, "R3 R6 victim hit", {resp_valid, resp_hit, miss_req}, 3'b110);
      chk(resp_ppn == walk(v), "R3 victim ppn", resp_ppn, walk(v));
      m_vv[slot] = m_pv[idx]; m_vp[slot] = m_pp[idx]; m_vval[slot] = m_pval[idx];
      m_pv[idx] = v; m_pp[idx] = walk(v); m_pval[idx] = 1;
      return;
    end
    chk(miss_req && !resp_valid, "R4 R8 miss raised", {miss_req, resp_valid}, 2'b10);
    chk(miss_vpn == v, "R4 miss vpn", miss_vpn, v);
    chk(!req_ready, "R9 not ready", req_ready, 0);
    if (stray) begin
      req_valid = 1'b1; req_vpn = v ^ 20'h00010;
      @(negedge clk); req_valid = 1'b0;
      chk(miss_req && !resp_valid && miss_vpn == v, "R9 R4 stray ignored", {miss_req, resp_valid}, 2'b10);
    end
    if (abort) begin
      do_flush();
      chk(!resp_valid, "R7 no response after abort", resp_valid, 0);
      return;
    end
    refill_valid = 1'b1; refill_vpn = v; refill_ppn = walk(v);
    @(negedge clk); refill_valid = 1'b0;
    chk(resp_valid && !resp_hit && !miss_req, "R4 refill response", {resp_valid, resp_hit, miss_req}, 3'b100);
    chk(resp_ppn == walk(v), "R4 refill ppn", resp_ppn, walk(v));
    if (m_pval[idx]) begin
      m_vv[m_ptr] = m_pv[idx]; m_vp[m_ptr] = m_pp[idx]; m_vval[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % VIC_N;
    end
    m_pv[idx] = v; m_pp[idx] = walk(v); m_pval[idx] = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(negedge clk);
    chk(!resp_valid && !resp_hit && !miss_req && req_ready, "R1 reset outputs",
        {resp_valid, resp_hit, miss_req, req_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!resp_valid && !miss_req && req_ready, "R1 idle after reset", {resp_valid, miss_req, req_ready}, 3'b001);

    // R1 R8: page 0 matches reset-cleared entries only if invalid entries match
    lookup(20'h00000, 0, 0);
    lookup(20'h00000, 0, 0);
    // R5 R6: ping-pong on slot 3
    lookup(20'h00A03, 0, 0);
    lookup(20'h00B03, 0, 0);
    lookup(20'h00A03, 0, 0);
    lookup(20'h00B03, 0, 0);
    lookup(20'h00B03, 0, 0);
    // R5: wrap the round-robin pointer with conflicts on slot 5
    for (int n = 0; n < 12; n++) lookup(VPN_W'((n << 8) | 5), 0, 0);
    for (int n = 0; n < 12; n++) lookup(VPN_W'((n << 8) | 5), 0, 0);
    // R9 stray request while a miss is pending
    lookup(20'h07707, 1, 0);
    // R7 flush with a pending miss, then earlier pages must miss again
    lookup(20'h03309, 0, 1);
    lookup(20'h00A03, 0, 0);
    do_flush();
    lookup(20'h00A03, 0, 0);

    for (int n = 0; n < 600; n++) begin
      logic [VPN_W-1:0] v;
      v = VPN_W'(($urandom_range(0, 6) << 8) | $urandom_range(0, 3));
      if ($urandom_range(0, 60) == 0) do_flush();
      else lookup(v, $urandom_range(0, 9) == 0, $urandom_range(0, 40) == 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule